// File: doc/BRIEF.md
# Reseedable Pseudo-Random Test Pattern Generator

This block produces a stream of pseudo-random test patterns from a maximal-length shift register with external XOR feedback. A test controller can push new seeds into it while a test is running. This lets a long test be steered toward patterns that a single free-running sequence would reach late or never. Each seed arrives over a valid/ready handshake. Two per-seed selects travel with it. One chooses whether the seed replaces the whole register or only its low-order slice. The other chooses whether generation pauses while the seed is loaded (static) or keeps running while the seed is merged into the advancing sequence (dynamic).

A small control state machine has three states. ST_IDLE holds the register with the output invalid. ST_RUN advances the register one step per cycle and offers the seed port. ST_LOAD is a one-cycle pause that writes a captured static seed. Its transitions are:
- ST_IDLE to ST_RUN when run is enabled.
- ST_RUN to ST_IDLE when run is withdrawn.
- ST_RUN to ST_LOAD when a static seed is accepted.
- ST_LOAD to ST_RUN or ST_IDLE, depending on the run enable.

A dynamic seed is taken within ST_RUN and does not change state. Any load whose result would be the all-zero lock-up state writes a fixed non-zero constant instead.

Top module: `lfsr_reseed_gen`

## Requirements
- R1: While reset is low, and after it is released until run is enabled, `pattern` is 0x01, `pattern_valid` is 0 and `seed_ready` is 0.
- R2: With default parameters, each cycle in ST_RUN without an accepted seed moves `pattern` from x to {x[6:0], x[7]^x[5]^x[4]^x[3]}. Starting from 0x01, the sequence returns to 0x01 after exactly 255 steps and never shows 0x00.
- R3: When `run_en` is low at a clock edge in ST_RUN, `pattern_valid` falls and `pattern` holds. When `run_en` is raised again, `pattern_valid` rises after one edge and stepping resumes from the held value.
- R4: `seed_ready` is high exactly in the cycles where `pattern_valid` is high (ST_RUN). It is low during a static load and while idle.
- R5: A static full seed (`seed_dyn`=0, `seed_full`=1) accepted at an edge gives one cycle with `pattern_valid`=0 and `pattern` unchanged. After the next edge, `pattern` equals the seed and `pattern_valid` is 1.
- R6: A static partial seed (`seed_dyn`=0, `seed_full`=0) has the same one-cycle gap. After it, `pattern` equals {old[7:4], seed[3:0]}, with the upper bits kept from before the load.
- R7: A dynamic full seed (`seed_dyn`=1, `seed_full`=1) accepted at an edge makes `pattern` equal the seed after that edge, and `pattern_valid` stays 1.
- R8: A dynamic partial seed (`seed_dyn`=1, `seed_full`=0) accepted at an edge makes `pattern` equal the normal next step of the old value XOR {0000, seed[3:0]}, and `pattern_valid` stays 1. Seeds accepted on consecutive cycles each apply.
- R9: Any load whose result would be 0x00 writes 0x5A instead.
- R10: Over one full period of 255 patterns, each output bit is 1 in exactly 128 patterns and 0 in exactly 127.
- R11: A seed offered while `seed_ready` is low is ignored. It changes neither `pattern` nor the seed written by a load already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Allows pattern generation |
| seed_valid | input | 1 | Seed offered |
| seed_ready | output | 1 | Seed can be accepted this cycle |
| seed_data | input | WIDTH | Seed value; the low PART_W bits are used for a partial seed |
| seed_full | input | 1 | 1: replace all stages; 0: low slice only |
| seed_dyn | input | 1 | 1: dynamic (keep generating); 0: static (pause) |
| pattern | output | WIDTH | Current test pattern |
| pattern_valid | output | 1 | Pattern is a generated test pattern |

## Verification
Two functions can fall on the same edge. In dynamic partial reseeding, the normal feedback step and the seed merge act on the register together. The bench provokes this by offering a new dynamic partial seed on every cycle for all sixteen slice values, and it judges each result against its own step-then-XOR arithmetic. The other collision is a seed offered during a static load. There, the pending write must win over the new offer, which is checked by changing `seed_data` during the gap.

// File: rtl/pg_pkg.sv
package pg_pkg;

    // Control state of the generator
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_LOAD = 2'd2
    } pg_state_e;

    // Operation applied to the shift register at the next edge
    typedef enum logic [2:0] {
        OP_HOLD     = 3'd0,
        OP_STEP     = 3'd1,
        OP_FULL     = 3'd2,
        OP_PART_SET = 3'd3,
        OP_STEP_XOR = 3'd4
    } pg_op_e;

endpackage

// File: rtl/pg_lfsr_core.sv
module pg_lfsr_core
    import pg_pkg::*;
#(
    parameter int unsigned     WIDTH      = 8,
    parameter int unsigned     PART_W     = 4,
    parameter logic [WIDTH-1:0] TAP_MASK   = 8'hB8,
    parameter logic [WIDTH-1:0] RESET_SEED = 8'h01,
    parameter logic [WIDTH-1:0] ZERO_FIX   = 8'h5A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pg_op_e           op,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] state_q
);

    localparam int unsigned UPPER_W = WIDTH - PART_W;

    logic [WIDTH-1:0] stepped;
    logic [WIDTH-1:0] part_ext;
    logic [WIDTH-1:0] part_set;
    logic [WIDTH-1:0] cand;
    logic [WIDTH-1:0] nxt;
    logic             is_load;
    logic             fb_bit;

    // External XOR feedback over the tapped stages
    assign fb_bit  = ^(state_q & TAP_MASK);
    assign stepped = {state_q[WIDTH-2:0], fb_bit};

    // The partial slice layout depends on whether a slice is narrower
    generate
        if (UPPER_W > 0) begin : g_slice
            assign part_ext = {{UPPER_W{1'b0}}, seed[PART_W-1:0]};
            assign part_set = {state_q[WIDTH-1:PART_W], seed[PART_W-1:0]};
        end else begin : g_whole
            assign part_ext = seed;
            assign part_set = seed;
        end
    endgenerate

    always_comb begin
        cand    = state_q;
        is_load = 1'b0;
        unique case (op)
            OP_HOLD:     cand = state_q;
            OP_STEP:     cand = stepped;
            OP_FULL:     begin cand = seed;                is_load = 1'b1; end
            OP_PART_SET: begin cand = part_set;            is_load = 1'b1; end
            OP_STEP_XOR: begin cand = stepped ^ part_ext;  is_load = 1'b1; end
            default:     cand = state_q;
        endcase
        // Lock-up guard: a load may never leave the register at zero
        nxt = (is_load && (cand == '0)) ? ZERO_FIX : cand;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_SEED;
        end else begin
            state_q <= nxt;
        end
    end

endmodule

// File: rtl/pg_seed_hold.sv
module pg_seed_hold #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [WIDTH-1:0] seed_in,
    input  logic             full_in,
    output logic [WIDTH-1:0] seed_q,
    output logic             full_q
);

    // Keeps a static seed for the pause cycle, so later offers cannot disturb it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed_q <= '0;
            full_q <= 1'b0;
        end else if (cap_en) begin
            seed_q <= seed_in;
            full_q <= full_in;
        end
    end

endmodule

// File: rtl/pg_ctrl.sv
module pg_ctrl
    import pg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run_en,
    input  logic   seed_valid,
    input  logic   seed_dyn,
    input  logic   seed_full,
    input  logic   pend_full,
    output pg_op_e op,
    output logic   seed_ready,
    output logic   pat_valid,
    output logic   cap_en,
    output logic   use_pending
);

    pg_state_e state_q;
    pg_state_e state_d;
    logic      accept;

    assign accept = seed_valid && (state_q == ST_RUN);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_d_check: state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = run_en ? ST_RUN : ST_IDLE;
            ST_RUN: begin
                if (accept && !seed_dyn) state_d = ST_LOAD;
                else                     state_d = run_en ? ST_RUN : ST_IDLE;
            end
            ST_LOAD: state_d = run_en ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and register operation
    always_comb begin
        op          = OP_HOLD;
        seed_ready  = 1'b0;
        pat_valid   = 1'b0;
        cap_en      = 1'b0;
        use_pending = 1'b0;
        unique case (state_q)
            ST_IDLE: op = OP_HOLD;
            ST_RUN: begin
                seed_ready = 1'b1;
                pat_valid  = 1'b1;
                if (accept && !seed_dyn) begin
                    cap_en = 1'b1;
                    op     = OP_HOLD;
                end else if (accept) begin
                    op = seed_full ? OP_FULL : OP_STEP_XOR;
                end else begin
                    op = run_en ? OP_STEP : OP_HOLD;
                end
            end
            ST_LOAD: begin
                use_pending = 1'b1;
                op          = pend_full ? OP_FULL : OP_PART_SET;
            end
            default: op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/lfsr_reseed_gen.sv
module lfsr_reseed_gen
    import pg_pkg::*;
#(
    parameter int unsigned      WIDTH      = 8,
    parameter int unsigned      PART_W     = 4,
    parameter logic [WIDTH-1:0] TAP_MASK   = 8'hB8,
    parameter logic [WIDTH-1:0] RESET_SEED = 8'h01,
    parameter logic [WIDTH-1:0] ZERO_FIX   = 8'h5A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             seed_valid,
    output logic             seed_ready,
    input  logic [WIDTH-1:0] seed_data,
    input  logic             seed_full,
    input  logic             seed_dyn,
    output logic [WIDTH-1:0] pattern,
    output logic             pattern_valid
);

    pg_op_e           op;
    logic             cap_en;
    logic             use_pending;
    logic [WIDTH-1:0] pend_seed;
    logic             pend_full;
    logic [WIDTH-1:0] seed_sel;

    pg_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .seed_valid  (seed_valid),
        .seed_dyn    (seed_dyn),
        .seed_full   (seed_full),
        .pend_full   (pend_full),
        .op          (op),
        .seed_ready  (seed_ready),
        .pat_valid   (pattern_valid),
        .cap_en      (cap_en),
        .use_pending (use_pending)
    );

    pg_seed_hold #(.WIDTH(WIDTH)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .seed_in (seed_data),
        .full_in (seed_full),
        .seed_q  (pend_seed),
        .full_q  (pend_full)
    );

    assign seed_sel = use_pending ? pend_seed : seed_data;

    pg_lfsr_core #(
        .WIDTH      (WIDTH),
        .PART_W     (PART_W),
        .TAP_MASK   (TAP_MASK),
        .RESET_SEED (RESET_SEED),
        .ZERO_FIX   (ZERO_FIX)
    ) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .seed    (seed_sel),
        .state_q (pattern)
    );

endmodule

// File: rtl/lfsr_reseed_gen_chk.sv
module lfsr_reseed_gen_chk #(
    parameter int unsigned      WIDTH    = 8,
    parameter logic [WIDTH-1:0] ZERO_FIX = 8'h5A
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_en,
    input logic             seed_valid,
    input logic             seed_ready,
    input logic [WIDTH-1:0] seed_data,
    input logic             seed_full,
    input logic             seed_dyn,
    input logic [WIDTH-1:0] pattern,
    input logic             pattern_valid
);

    logic take;
    assign take = seed_valid && seed_ready;

    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pattern != '0); // R2

    AST_READY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        seed_ready |-> pattern_valid); // R4

    AST_STATIC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        take && !seed_dyn |=> !pattern_valid && !seed_ready && $stable(pattern)); // R5

    AST_DYN_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        take && seed_dyn && run_en |=> pattern_valid); // R7

    AST_DYN_FULL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        take && seed_dyn && seed_full && (seed_data != '0) |=> pattern == $past(seed_data)); // R7

    AST_ZERO_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        take && seed_dyn && seed_full && (seed_data == '0) |=> pattern == ZERO_FIX); // R9

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        pattern_valid && run_en && !take |=> pattern[WIDTH-1:1] == $past(pattern[WIDTH-2:0])); // R2

    AST_RUN_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pattern_valid && !run_en && !take |=> !pattern_valid && $stable(pattern)); // R3

endmodule

bind lfsr_reseed_gen lfsr_reseed_gen_chk #(
    .WIDTH    (WIDTH),
    .ZERO_FIX (ZERO_FIX)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_en        (run_en),
    .seed_valid    (seed_valid),
    .seed_ready    (seed_ready),
    .seed_data     (seed_data),
    .seed_full     (seed_full),
    .seed_dyn      (seed_dyn),
    .pattern       (pattern),
    .pattern_valid (pattern_valid)
);

// File: tb/lfsr_reseed_gen_test.sv
`timescale 1ns/1ps
module lfsr_reseed_gen_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       run_en;
    logic       seed_valid;
    logic       seed_ready;
    logic [7:0] seed_data;
    logic       seed_full;
    logic       seed_dyn;
    logic [7:0] pattern;
    logic       pattern_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    lfsr_reseed_gen uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_en        (run_en),
        .seed_valid    (seed_valid),
        .seed_ready    (seed_ready),
        .seed_data     (seed_data),
        .seed_full     (seed_full),
        .seed_dyn      (seed_dyn),
        .pattern       (pattern),
        .pattern_valid (pattern_valid)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] nx(input logic [7:0] x);
        return {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
    endfunction

    function automatic logic [7:0] guard(input logic [7:0] x);
        return (x == 8'h00) ? 8'h5A : x;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one edge and sample 1 ns after it
    task automatic step();
        @(posedge clk);
        #1;
        cycles++;
    endtask

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp;
        logic [7:0] other;
        int         ones [8];
        bit         seen [256];
        int         distinct;
        bit         zero_seen;

        rst_n = 1'b0; run_en = 1'b0; seed_valid = 1'b0;
        seed_data = 8'h00; seed_full = 1'b0; seed_dyn = 1'b0;
        repeat (3) step();
        check("R1 pattern in reset", pattern, 8'h01);
        check("R1 valid in reset", pattern_valid, 1'b0);
        check("R1 ready in reset", seed_ready, 1'b0);
        rst_n = 1'b1;
        step();
        check("R1 pattern idle after reset", pattern, 8'h01);
        check("R1 valid idle after reset", pattern_valid, 1'b0);

        // R2 / R10: one full period
        run_en = 1'b1;
        step();
        exp = 8'h01;
        for (int b = 0; b < 8; b++) ones[b] = 0;
        for (int v = 0; v < 256; v++) seen[v] = 1'b0;
        distinct = 0; zero_seen = 1'b0;
        for (int i = 0; i < 255; i++) begin
            check("R2 step value", pattern, exp);
            check("R4 ready while running", seed_ready, 1'b1);
            if (!seen[pattern]) distinct++;
            seen[pattern] = 1'b1;
            if (pattern == 8'h00) zero_seen = 1'b1;
            for (int b = 0; b < 8; b++) ones[b] += pattern[b];
            step();
            exp = nx(exp);
        end
        check("R2 period returns to start", pattern, 8'h01);
        check("R2 distinct patterns", distinct, 255);
        check("R2 zero never seen", zero_seen, 1'b0);
        for (int b = 0; b < 8; b++) check("R10 ones per bit", ones[b], 128);

        // R3 / R11: run off, offer ignored while idle
        run_en = 1'b0;
        step();
        check("R3 valid falls", pattern_valid, 1'b0);
        check("R3 pattern held", pattern, exp);
        check("R4 ready low idle", seed_ready, 1'b0);
        seed_valid = 1'b1; seed_dyn = 1'b1; seed_full = 1'b1; seed_data = 8'h33;
        step();
        check("R11 idle offer ignored", pattern, exp);
        seed_valid = 1'b0;
        run_en = 1'b1;
        step();
        check("R3 valid back", pattern_valid, 1'b1);
        check("R3 resumes from held", pattern, exp);
        step();
        exp = nx(exp);
        check("R3 stepping resumes", pattern, exp);

        // R5 / R9 / R11: static full seeds, new offers during the gap
        foreach (other[i]) other[i] = 1'b0;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] sd;
            sd = (k == 5) ? 8'h00 : 8'(8'h13 * (k + 1) + 8'h20);
            seed_valid = 1'b1; seed_dyn = 1'b0; seed_full = 1'b1; seed_data = sd;
            step();
            check("R5 gap valid low", pattern_valid, 1'b0);
            check("R4 ready low in load", seed_ready, 1'b0);
            check("R5 gap pattern held", pattern, exp);
            seed_data = 8'h77;
            step();
            seed_valid = 1'b0;
            exp = guard(sd);
            if (k == 5) check("R9 zero full seed replaced", pattern, 8'h5A);
            else        check("R5 pattern is seed", pattern, exp);
            check("R11 offer during load ignored", pattern, exp);
            check("R5 valid after load", pattern_valid, 1'b1);
            step();
            exp = nx(exp);
            check("R5 steps from seed", pattern, exp);
        end

        // R6: static partial seeds, all slice values
        for (int s = 0; s < 16; s++) begin
            seed_valid = 1'b1; seed_dyn = 1'b0; seed_full = 1'b0;
            seed_data = {4'hF, 4'(s)};
            step();
            check("R6 gap valid low", pattern_valid, 1'b0);
            check("R6 gap pattern held", pattern, exp);
            seed_valid = 1'b0;
            step();
            exp = guard({exp[7:4], 4'(s)});
            check("R6 low slice replaced", pattern, exp);
            step();
            exp = nx(exp);
        end

        // R9: partial static load onto a zero upper nibble
        seed_valid = 1'b1; seed_dyn = 1'b0; seed_full = 1'b1; seed_data = 8'h03;
        step(); seed_valid = 1'b0; step();
        seed_valid = 1'b1; seed_full = 1'b0; seed_data = 8'hF0;
        step(); seed_valid = 1'b0; step();
        exp = 8'h5A;
        check("R9 zero partial result replaced", pattern, exp);

        // R8: dynamic partial seeds on consecutive cycles
        for (int s = 0; s < 16; s++) begin
            seed_valid = 1'b1; seed_dyn = 1'b1; seed_full = 1'b0;
            seed_data = {4'hA, 4'(s)};
            step();
            exp = guard(nx(exp) ^ {4'h0, 4'(s)});
            check("R8 step xor slice", pattern, exp);
            check("R8 valid stays", pattern_valid, 1'b1);
        end

        // R7 / R9: dynamic full seeds
        for (int k = 0; k < 4; k++) begin
            logic [7:0] sd;
            sd = (k == 3) ? 8'h00 : 8'(8'h41 + 8'h2B * k);
            seed_valid = 1'b1; seed_dyn = 1'b1; seed_full = 1'b1; seed_data = sd;
            step();
            exp = guard(sd);
            check("R7 dynamic full loads seed", pattern, exp);
            check("R7 valid stays", pattern_valid, 1'b1);
        end
        seed_valid = 1'b0;
        step();
        exp = nx(exp);
        check("R7 stepping after dynamic load", pattern, exp);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule